// File: doc/BRIEF.md
# Indexed LCD Register and Display-Memory Port

This block is the host-facing access port of a dot-matrix LCD controller. The host sees a single byte-wide register window and a register-select input. With register-select low, a write loads an index register. With register-select high, the access goes to whichever internal register the index names. The indexed registers are a control register, an address register and a data register.

The address register holds a column (X) and row (Y) position in a display RAM of 5 columns by 32 rows of bytes. The host reads and writes that RAM only through the data register. Each data-register access moves the X/Y position forward, either row-first or column-first, so the host can stream bytes across the whole memory without reloading the address.

A second, read-only port lets the display scan logic fetch any RAM byte every cycle. It works independently of host activity.

Top module: `lcd_host_port`

## Requirements
- R1: A host write with `host_sel` low loads the low 3 bits of `host_wdata` into the index register. Later accesses with `host_sel` high go to the indexed register: index 0 is control, 1 is address, 2 is data, and 3 to 7 are unused. Writes to unused indices have no effect.
- R2: Only the data register is readable. A read with `host_sel` low, or of index 0, 1 or 3 to 7, returns 0x00. Read data appears on `host_rdata` one cycle after the `host_rd` strobe and holds until the next read.
- R3: In the control register only bit 0 (increment order) exists. Bits 7:1 are ignored, so writing 0xFE selects order 0.
- R4: The address register takes X from bits 7:5 and Y from bits 4:0. An X value above 4 loads as X = 0. Data-register writes store the byte at the current (X,Y).
- R5: A data-register read returns the byte at the current (X,Y), taken before the position advances.
- R6: With increment order 0, each data access keeps X and adds 1 to Y. The access made at Y = 31 sets Y to 0 and adds 1 to X in the same step.
- R7: With increment order 1, each data access keeps Y and adds 1 to X. The access made at X = 4 sets X to 0 and adds 1 to Y in the same step.
- R8: In either order, the access made at (X,Y) = (4,31) moves the position to (0,0).
- R9: The display port returns on `disp_rdata` the byte at (`disp_x`,`disp_y`) one cycle after the address is presented, every cycle, independent of host activity. An X above 4 returns 0x00.
- R10: When a host write and a display read hit the same location in one cycle, the display port returns the old byte. The new byte is returned on the following cycle.
- R11: Reset is synchronous and active low. It sets the index to 0, the position to (0,0), the increment order to 0 and `host_rdata` to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_sel | input | 1 | Register select: 0 = index register, 1 = indexed register |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, registered |
| disp_x | input | 3 | Display-side column address |
| disp_y | input | 5 | Display-side row address |
| disp_rdata | output | 8 | Display-side read data, registered |

## Verification
Two activities can land in the same cycle: a host write through the data register and a display-side fetch of the same RAM byte. The bench first stores a known byte at one location and reloads the address. It then drives a new host write and points the display port at that same (X,Y) on the same clock edge. The check passes only if the display port returns the stored byte on the first following cycle and the newly written byte one cycle later.

// File: rtl/lcd_port_pkg.sv
// Package lcd_port_pkg
// Shared constants and the register index encoding of the LCD host port.
// Assumes the index register is IDX_W bits wide. Values with no entry
// below are unused indices.
package lcd_port_pkg;
    localparam int IDX_W = 3;

    typedef enum logic [IDX_W-1:0] {
        IDX_CTRL = 3'd0,
        IDX_ADDR = 3'd1,
        IDX_DATA = 3'd2
    } reg_idx_e;
endpackage

// File: rtl/lcd_addr_step.sv
// Module lcd_addr_step
// Holds the X/Y display position. It loads the position from the host and
// advances it on each data access, in column-first or row-first order, with
// a carry into the other axis. Assumes load and step are never high together.
// If they are, load wins.
module lcd_addr_step #(
    parameter int XN = 5,
    parameter int YN = 32,
    parameter int XW = 3,
    parameter int YW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [XW-1:0] load_x,
    input  logic [YW-1:0] load_y,
    input  logic          step,
    input  logic          x_first,
    output logic [XW-1:0] cur_x,
    output logic [YW-1:0] cur_y
);
    localparam logic [XW-1:0] X_MAX = XW'(XN - 1);
    localparam logic [YW-1:0] Y_MAX = YW'(YN - 1);

    logic [XW-1:0] nx;
    logic [YW-1:0] ny;

    // Next position after one access, for the selected order
    always_comb begin
        nx = cur_x;
        ny = cur_y;
        if (x_first) begin
            if (cur_x == X_MAX) begin
                nx = '0;
                ny = (cur_y == Y_MAX) ? '0 : cur_y + YW'(1);
            end else begin
                nx = cur_x + XW'(1);
            end
        end else begin
            if (cur_y == Y_MAX) begin
                ny = '0;
                nx = (cur_x == X_MAX) ? '0 : cur_x + XW'(1);
            end else begin
                ny = cur_y + YW'(1);
            end
        end
    end

    // Position register: reset, host load with range clamp, or step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_x <= '0;
            cur_y <= '0;
        end else if (load) begin
            cur_x <= (load_x > X_MAX) ? '0 : load_x;
            cur_y <= (load_y > Y_MAX) ? '0 : load_y;
        end else if (step) begin
            cur_x <= nx;
            cur_y <= ny;
        end
    end

    a_r6_row_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && !x_first && cur_y != Y_MAX)
        |=> (cur_y == $past(cur_y) + YW'(1)) && (cur_x == $past(cur_x)));

    a_r6_row_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && !x_first && cur_y == Y_MAX)
        |=> (cur_y == YW'(0)) &&
            (cur_x == (($past(cur_x) == X_MAX) ? XW'(0) : $past(cur_x) + XW'(1))));

    a_r7_col_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && x_first && cur_x != X_MAX)
        |=> (cur_x == $past(cur_x) + XW'(1)) && (cur_y == $past(cur_y)));

    a_r7_col_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && x_first && cur_x == X_MAX)
        |=> (cur_x == XW'(0)) &&
            (cur_y == (($past(cur_y) == Y_MAX) ? YW'(0) : $past(cur_y) + YW'(1))));

    a_r4_x_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cur_x <= X_MAX));
endmodule

// File: rtl/lcd_dpram.sv
// Module lcd_dpram
// Display RAM with one host read/write port and one display read-only port.
// Both ports have registered reads. A write and a read of the same word in
// one cycle give the old word on the read port. Assumes b_addr is in range
// whenever b_valid is high.
module lcd_dpram #(
    parameter int DEPTH = 160,
    parameter int AW    = 8,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          a_rd,
    input  logic          a_we,
    input  logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_wdata,
    output logic [DW-1:0] a_rdata,
    input  logic          b_valid,
    input  logic [AW-1:0] b_addr,
    output logic [DW-1:0] b_rdata
);
    logic [DW-1:0] mem [DEPTH];

    // Host port: write, or registered read when requested
    always_ff @(posedge clk) begin
        if (a_we) begin
            mem[a_addr] <= a_wdata;
        end
        if (!rst_n) begin
            a_rdata <= '0;
        end else if (a_rd) begin
            a_rdata <= mem[a_addr];
        end
    end

    // Display port: registered read every cycle, zero when out of range
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_rdata <= '0;
        end else begin
            b_rdata <= b_valid ? mem[b_addr] : '0;
        end
    end

    a_r9_disp_range_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !b_valid |=> (b_rdata == '0));
endmodule

// File: rtl/lcd_host_port.sv
// Module lcd_host_port
// Host register window of the LCD controller. It decodes the index, control,
// address and data registers, drives the display RAM host port and steps the
// X/Y position after each data access. Assumes host_wr and host_rd are
// single-cycle strobes and are not both high. If they are, the write is taken.
module lcd_host_port
    import lcd_port_pkg::*;
#(
    parameter int XN = 5,
    parameter int YN = 32,
    parameter int DW = 8,
    localparam int XW = $clog2(XN),
    localparam int YW = $clog2(YN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_sel,
    input  logic          host_wr,
    input  logic          host_rd,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    input  logic [XW-1:0] disp_x,
    input  logic [YW-1:0] disp_y,
    output logic [DW-1:0] disp_rdata
);
    localparam int DEPTH = XN * YN;
    localparam int AW    = $clog2(DEPTH);
    localparam logic [XW-1:0] X_MAX = XW'(XN - 1);
    localparam logic [YW-1:0] Y_MAX = YW'(YN - 1);

    logic [IDX_W-1:0] idx_q;
    logic             inc_q;
    logic             rd_data_q;
    logic [XW-1:0]    cur_x;
    logic [YW-1:0]    cur_y;
    logic [DW-1:0]    ram_rdata;
    logic [AW-1:0]    host_addr;
    logic [AW-1:0]    disp_addr;
    logic             disp_ok;
    logic             acc_data, wr_idx, wr_ctrl, wr_addr, data_wr, data_rd;

    // Register-window decode of the current host strobe
    always_comb begin
        acc_data = host_sel && (idx_q == IDX_DATA);
        wr_idx   = host_wr && !host_sel;
        wr_ctrl  = host_wr && host_sel && (idx_q == IDX_CTRL);
        wr_addr  = host_wr && host_sel && (idx_q == IDX_ADDR);
        data_wr  = host_wr && acc_data;
        data_rd  = host_rd && !host_wr && acc_data;
    end

    // Linear RAM addresses for the host position and the display position
    always_comb begin
        host_addr = AW'(cur_x) * AW'(YN) + AW'(cur_y);
        disp_ok   = (disp_x <= X_MAX) && (disp_y <= Y_MAX);
        disp_addr = disp_ok ? AW'(disp_x) * AW'(YN) + AW'(disp_y) : '0;
    end

    // Index, control and read-source registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q     <= '0;
            inc_q     <= 1'b0;
            rd_data_q <= 1'b0;
        end else begin
            if (wr_idx) begin
                idx_q <= host_wdata[IDX_W-1:0];
            end
            if (wr_ctrl) begin
                inc_q <= host_wdata[0];
            end
            if (host_rd && !host_wr) begin
                rd_data_q <= acc_data;
            end
        end
    end

    assign host_rdata = rd_data_q ? ram_rdata : '0;

    lcd_addr_step #(.XN(XN), .YN(YN), .XW(XW), .YW(YW)) i_step (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (wr_addr),
        .load_x  (host_wdata[YW +: XW]),
        .load_y  (host_wdata[YW-1:0]),
        .step    (data_wr || data_rd),
        .x_first (inc_q),
        .cur_x   (cur_x),
        .cur_y   (cur_y)
    );

    lcd_dpram #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) i_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_rd    (data_rd),
        .a_we    (data_wr),
        .a_addr  (host_addr),
        .a_wdata (host_wdata),
        .a_rdata (ram_rdata),
        .b_valid (disp_ok),
        .b_addr  (disp_addr),
        .b_rdata (disp_rdata)
    );

    a_r2_other_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !host_wr && !(host_sel && idx_q == IDX_DATA))
        |=> (host_rdata == '0));

    a_r1_index_load: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !host_sel) |=> (idx_q == $past(host_wdata[IDX_W-1:0])));
endmodule

// File: tb/test_lcd_host_port.sv
`timescale 1ns/1ps
module test_lcd_host_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_sel = 1'b0;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic [2:0] disp_x = 3'd0;
    logic [4:0] disp_y = 5'd0;
    logic [7:0] disp_rdata;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    lcd_host_port i_lcd_host_port (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .disp_x(disp_x), .disp_y(disp_y), .disp_rdata(disp_rdata)
    );

    // Vector: {req[3:0], is_read, sel, data[7:0], expected[7:0]}
    localparam int NV = 19;
    localparam logic [21:0] VEC [NV] = '{
        {4'd1,  1'b0, 1'b0, 8'h01, 8'h00}, // R1 index -> address
        {4'd4,  1'b0, 1'b1, 8'h00, 8'h00}, // R4 position (0,0)
        {4'd1,  1'b0, 1'b0, 8'h02, 8'h00}, // R1 index -> data
        {4'd4,  1'b0, 1'b1, 8'h11, 8'h00}, // R4 store (0,0)
        {4'd4,  1'b0, 1'b1, 8'h22, 8'h00}, // R4 store (0,1)
        {4'd4,  1'b0, 1'b1, 8'h33, 8'h00}, // R4 store (0,2)
        {4'd1,  1'b0, 1'b0, 8'h01, 8'h00},
        {4'd4,  1'b0, 1'b1, 8'h00, 8'h00},
        {4'd1,  1'b0, 1'b0, 8'h02, 8'h00},
        {4'd5,  1'b1, 1'b1, 8'h00, 8'h11}, // R5 read (0,0)
        {4'd5,  1'b1, 1'b1, 8'h00, 8'h22}, // R5 read (0,1)
        {4'd5,  1'b1, 1'b1, 8'h00, 8'h33}, // R5 read (0,2)
        {4'd2,  1'b1, 1'b0, 8'h00, 8'h00}, // R2 index reg reads zero
        {4'd1,  1'b0, 1'b0, 8'h00, 8'h00},
        {4'd2,  1'b1, 1'b1, 8'h00, 8'h00}, // R2 control reads zero
        {4'd1,  1'b0, 1'b0, 8'h01, 8'h00},
        {4'd2,  1'b1, 1'b1, 8'h00, 8'h00}, // R2 address reads zero
        {4'd1,  1'b0, 1'b0, 8'h05, 8'h00},
        {4'd2,  1'b1, 1'b1, 8'h00, 8'h00}  // R2 unused index reads zero
    };

    task automatic check(input int req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL R%0d actual=%02h expected=%02h", req, got, exp);
        end
    endtask

    task automatic host_write(input logic sel, input logic [7:0] d);
        @(negedge clk);
        host_sel = sel; host_wr = 1'b1; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_read(input logic sel, output logic [7:0] got);
        @(negedge clk);
        host_sel = sel; host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        got = host_rdata;
    endtask

    task automatic set_pos(input logic [2:0] x, input logic [4:0] y);
        host_write(1'b0, 8'h01);
        host_write(1'b1, {x, y});
        host_write(1'b0, 8'h02);
    endtask

    task automatic set_order(input logic [7:0] v);
        host_write(1'b0, 8'h00);
        host_write(1'b1, v);
    endtask

    task automatic disp_check(input int req, input logic [2:0] x, input logic [4:0] y,
                              input logic [7:0] exp);
        @(negedge clk);
        disp_x = x; disp_y = y;
        @(negedge clk);
        check(req, disp_rdata, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] got;
        repeat (3) @(negedge clk);
        check(11, host_rdata, 8'h00);                 // R11 read data cleared
        rst_n = 1'b1;

        // R11: index 0 after reset, so select data; position (0,0), order 0
        host_write(1'b0, 8'h02);
        host_write(1'b1, 8'hC3);
        host_write(1'b1, 8'h3C);
        disp_check(11, 3'd0, 5'd0, 8'hC3);
        disp_check(11, 3'd0, 5'd1, 8'h3C);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][17]) begin
                host_read(VEC[i][16], got);
                check(int'(VEC[i][21:18]), got, VEC[i][7:0]);
            end else begin
                host_write(VEC[i][16], VEC[i][15:8]);
            end
        end
        // R1: write to unused index 5 is ignored; (0,3) stays unwritten
        host_write(1'b0, 8'h02);
        host_read(1'b1, got);                         // position was (0,3)
        host_write(1'b0, 8'h05);
        host_write(1'b1, 8'hAB);
        disp_check(1, 3'd0, 5'd3, got);

        // R6: row-first with carry into X
        set_pos(3'd2, 5'd30);
        host_write(1'b1, 8'hA1);
        host_write(1'b1, 8'hA2);
        host_write(1'b1, 8'hA3);
        disp_check(6, 3'd2, 5'd30, 8'hA1);
        disp_check(6, 3'd2, 5'd31, 8'hA2);
        disp_check(6, 3'd3, 5'd0,  8'hA3);

        // R7: column-first with carry into Y
        set_order(8'h01);
        set_pos(3'd3, 5'd7);
        host_write(1'b1, 8'hB1);
        host_write(1'b1, 8'hB2);
        host_write(1'b1, 8'hB3);
        disp_check(7, 3'd3, 5'd7, 8'hB1);
        disp_check(7, 3'd4, 5'd7, 8'hB2);
        disp_check(7, 3'd0, 5'd8, 8'hB3);

        // R8: wrap from the last location, both orders
        set_pos(3'd4, 5'd31);
        host_write(1'b1, 8'h77);
        host_write(1'b1, 8'h78);
        disp_check(8, 3'd4, 5'd31, 8'h77);
        disp_check(8, 3'd0, 5'd0,  8'h78);
        set_order(8'h00);
        set_pos(3'd4, 5'd31);
        host_write(1'b1, 8'h99);
        host_write(1'b1, 8'h9A);
        disp_check(8, 3'd4, 5'd31, 8'h99);
        disp_check(8, 3'd0, 5'd0,  8'h9A);

        // R3: only bit 0 of control counts; 0xFE means row-first
        set_order(8'h01);
        set_order(8'hFE);
        set_pos(3'd1, 5'd0);
        host_write(1'b1, 8'h5A);
        host_write(1'b1, 8'h5B);
        disp_check(3, 3'd1, 5'd1, 8'h5B);

        // R4: X above 4 loads as 0
        set_pos(3'd7, 5'd3);
        host_write(1'b1, 8'h44);
        disp_check(4, 3'd0, 5'd3, 8'h44);

        // R9: out-of-range display column reads zero
        disp_check(9, 3'd6, 5'd2, 8'h00);

        // R10: same-cycle host write and display read of one location
        set_pos(3'd2, 5'd5);
        host_write(1'b1, 8'h12);
        set_pos(3'd2, 5'd5);
        @(negedge clk);
        host_sel = 1'b1; host_wr = 1'b1; host_wdata = 8'hEE;
        disp_x = 3'd2; disp_y = 5'd5;
        @(negedge clk);
        host_wr = 1'b0;
        check(10, disp_rdata, 8'h12);
        @(negedge clk);
        check(10, disp_rdata, 8'hEE);

        // R5: read returns byte before advance; next read sees (2,6)
        set_pos(3'd2, 5'd5);
        host_read(1'b1, got);
        check(5, got, 8'hEE);
        host_write(1'b1, 8'h66);                      // lands on (2,6)
        disp_check(5, 3'd2, 5'd6, 8'h66);

        // R2: read data holds after the strobe
        @(negedge clk);
        check(2, host_rdata, 8'hEE);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule